// File: doc/BRIEF.md
# Serial Flash Array Parallel Bridge

This controller connects a parallel command port to an on-chip flash array that can only be reached through two serial shift chains. One chain carries a word address, the other a data word. Each chain has its own serial clock and a select line that chooses between shifting and a chain-specific action. The array also has program and erase request inputs and a busy output. The bridge turns one parallel command into the right sequence of serial clock pulses. It then returns read data as a whole word.

A command carries a two-bit operation code, an address and a write word. There are four operations. A random read sends the full address serially, captures the addressed word into the data chain and shifts it out. A stream-next read does not send an address again. Instead it pulses the address clock once with select low, which moves the array's own address register forward by one, and then reads. A program shifts the write word into the data chain and raises the program request. An erase sends the address and raises the erase request. For both program and erase, the request line stays high until the array's busy output has risen and fallen again. The serial clocks run at a fraction of the system clock, and their low and high phases are set by a parameter.

Top module: `sfa_bridge`

## Requirements
- R1: After reset, `ready` is high, `done` is low, and every serial clock, select line, program request and erase request is low.
- R2: A command is taken on a clock edge where `cmd_valid` and `ready` are both high. Operation codes are 00 read, 01 stream-next, 10 program and 11 erase. `ready` then stays low until the operation finishes. It returns high in the same cycle as a `done` pulse that lasts exactly one cycle.
- R3: A full address load holds the address select high and gives exactly ADDR_W address clock pulses. Each pulse carries one address bit, most significant bit first.
- R4: A read gives one data clock pulse with the data select low, which captures the array word. It then gives DATA_W data clock pulses with the data select high. The serial output bits, taken most significant first, form `rdata`, which is valid when `done` pulses.
- R5: A stream-next that follows a read or another stream-next gives exactly one address clock pulse with the address select low and no address shifting. It returns the word at the previous address plus one, and the address wraps from the top of the space to zero.
- R6: A stream-next that follows reset, a program or an erase does a full address load of `cmd_addr`, just like a read.
- R7: A program shifts `cmd_wdata` into the data chain, most significant bit first, over DATA_W pulses with the data select high. Only after that does it raise the program request. The request stays high until the array's busy output has risen and then fallen.
- R8: An erase does a full address load and then raises the erase request. The erase request is held under the same busy rule as R7. The program and erase requests are never high together.
- R9: Each serial clock high phase lasts exactly PHASE_CYC system cycles, and each low phase lasts at least PHASE_CYC cycles. A select or serial data line changes only while its clock is low.
- R10: A command presented while `ready` is low is ignored. It causes no serial activity, no `done` and no change to array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code (00 read, 01 stream-next, 10 program, 11 erase) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to program |
| ready | output | 1 | High when a command can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read word, valid at `done` |
| arr_aclk | output | 1 | Address chain serial clock |
| arr_ashift | output | 1 | Address select: high shifts, low increments |
| arr_adin | output | 1 | Address serial bit |
| arr_dclk | output | 1 | Data chain serial clock |
| arr_dshift | output | 1 | Data select: high shifts, low captures the array word |
| arr_ddin | output | 1 | Serial bit into the data chain |
| arr_ddout | input | 1 | Serial bit out of the data chain |
| arr_prog | output | 1 | Program request |
| arr_erase | output | 1 | Erase request |
| arr_busy | input | 1 | Array busy with program or erase |

## Verification
Suppose the controller loses track of whether a stream is still legal. The next stream-next then shows the wrong number of address clock pulses, and the word returned comes from a different address. Both appear at the very next `done`. A miscount in a shift run changes how many pulses the array model sees and shifts the data it returns by one or more bits, so the comparison made at that completion fails. If a request is dropped too early or never released, the array model sees a busy-rule violation within a few cycles, or the next command never gets `ready` and the run times out.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

   typedef enum logic [1:0] {
      OP_READ   = 2'b00,
      OP_STREAM = 2'b01,
      OP_PROG   = 2'b10,
      OP_ERASE  = 2'b11
   } sfa_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ALOAD = 3'd1,
      ST_CAPT  = 3'd2,
      ST_DOUT  = 3'd3,
      ST_WLOAD = 3'd4,
      ST_HOLD  = 3'd5
   } sfa_state_e;

endpackage

// File: rtl/sfa_chain.sv
// Drives one serial shift chain: a run of N clock pulses with a fixed select
// level, sending a word MSB first and sampling the return bit at each rise.
module sfa_chain #(
   parameter int W         = 9,
   parameter int PHASE_CYC = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       sel_in,
   input  logic [$clog2(W+1)-1:0]     npulse,
   input  logic [W-1:0]               word,
   input  logic                       ser_in,
   output logic                       sclk,
   output logic                       sel,
   output logic                       sdo,
   output logic [W-1:0]               cap,
   output logic                       fin
);
   localparam int CW = $clog2(W + 1);

   logic          active;
   logic          tick;
   logic [W-1:0]  shreg;
   logic [CW-1:0] left;

   generate
      if (W < 2) begin : g_bad_width
         $error("sfa_chain: W must be at least 2");
      end
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("sfa_chain: PHASE_CYC must be at least 1");
      end

      if (PHASE_CYC == 1) begin : g_phase_direct
         assign tick = active;
      end else begin : g_phase_count
         localparam int PW = $clog2(PHASE_CYC);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pcnt <= '0;
            else if (!active)                        pcnt <= '0;
            else if (pcnt == PW'(PHASE_CYC - 1))     pcnt <= '0;
            else                                     pcnt <= pcnt + 1'b1;
         end
         assign tick = active && (pcnt == PW'(PHASE_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b0;
         sel    <= 1'b0;
         sdo    <= 1'b0;
         shreg  <= '0;
         left   <= '0;
         cap    <= '0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            shreg  <= word;
            left   <= npulse;
            sel    <= sel_in;
            sdo    <= word[W-1];
            sclk   <= 1'b0;
         end else if (tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
               cap  <= {cap[W-2:0], ser_in};
            end else begin
               sclk  <= 1'b0;
               shreg <= {shreg[W-2:0], 1'b0};
               sdo   <= shreg[W-2];
               left  <= left - 1'b1;
               if (left == CW'(1)) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
                  sel    <= 1'b0;
                  sdo    <= 1'b0;
               end
            end
         end
      end
   end

   // Lines seen by the array must be steady while its clock is high.
   assert_sel_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> ($stable(sel) && $stable(sdo)));

   assert_nonzero_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (npulse != '0));

   assert_fin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !sclk);

endmodule

// File: rtl/sfa_hold.sv
// Raises program or erase request and keeps it up until busy rises then falls.
module sfa_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic go_prog,
   input  logic go_erase,
   input  logic busy,
   output logic prog,
   output logic erase,
   output logic fin
);
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog  <= 1'b0;
         erase <= 1'b0;
         seen  <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go_prog) begin
            prog <= 1'b1;
            seen <= 1'b0;
         end else if (go_erase) begin
            erase <= 1'b1;
            seen  <= 1'b0;
         end else if (prog || erase) begin
            if (!seen) begin
               if (busy) seen <= 1'b1;
            end else if (!busy) begin
               prog  <= 1'b0;
               erase <= 1'b0;
               seen  <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end

   assert_hold_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((prog || erase) && busy) |=> (prog || erase));

   assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog && erase));

endmodule

// File: rtl/sfa_bridge.sv
module sfa_bridge #(
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 16,
   parameter int PHASE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              arr_aclk,
   output logic              arr_ashift,
   output logic              arr_adin,
   output logic              arr_dclk,
   output logic              arr_dshift,
   output logic              arr_ddin,
   input  logic              arr_ddout,
   output logic              arr_prog,
   output logic              arr_erase,
   input  logic              arr_busy
);
   import sfa_pkg::*;

   localparam int ACW = $clog2(ADDR_W + 1);
   localparam int DCW = $clog2(DATA_W + 1);

   generate
      if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_dims
         $error("sfa_bridge: ADDR_W and DATA_W must be at least 2");
      end
   endgenerate

   sfa_state_e        st;
   sfa_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              stream_ok;
   logic              load_q;

   logic              a_start, a_sel, a_fin;
   logic [ACW-1:0]    a_n;
   logic [ADDR_W-1:0] a_word, a_cap;
   logic              d_start, d_sel, d_fin;
   logic [DCW-1:0]    d_n;
   logic [DATA_W-1:0] d_word, d_cap;
   logic              go_prog, go_erase, h_fin;

   sfa_chain #(.W(ADDR_W), .PHASE_CYC(PHASE_CYC)) u_addr_chain (
      .clk(clk), .rst_n(rst_n), .start(a_start), .sel_in(a_sel),
      .npulse(a_n), .word(a_word), .ser_in(arr_adin),
      .sclk(arr_aclk), .sel(arr_ashift), .sdo(arr_adin),
      .cap(a_cap), .fin(a_fin));

   sfa_chain #(.W(DATA_W), .PHASE_CYC(PHASE_CYC)) u_data_chain (
      .clk(clk), .rst_n(rst_n), .start(d_start), .sel_in(d_sel),
      .npulse(d_n), .word(d_word), .ser_in(arr_ddout),
      .sclk(arr_dclk), .sel(arr_dshift), .sdo(arr_ddin),
      .cap(d_cap), .fin(d_fin));

   sfa_hold u_hold (
      .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_erase(go_erase),
      .busy(arr_busy), .prog(arr_prog), .erase(arr_erase), .fin(h_fin));

   assign ready = (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         op_q      <= OP_READ;
         addr_q    <= '0;
         wdata_q   <= '0;
         stream_ok <= 1'b0;
         load_q    <= 1'b0;
         a_start   <= 1'b0;
         a_sel     <= 1'b0;
         a_n       <= '0;
         a_word    <= '0;
         d_start   <= 1'b0;
         d_sel     <= 1'b0;
         d_n       <= '0;
         d_word    <= '0;
         go_prog   <= 1'b0;
         go_erase  <= 1'b0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         a_start  <= 1'b0;
         d_start  <= 1'b0;
         go_prog  <= 1'b0;
         go_erase <= 1'b0;
         done     <= 1'b0;
         unique case (st)
            ST_IDLE: if (cmd_valid) begin
               op_q    <= sfa_op_e'(cmd_op);
               addr_q  <= cmd_addr;
               wdata_q <= cmd_wdata;
               a_start <= 1'b1;
               st      <= ST_ALOAD;
               if (sfa_op_e'(cmd_op) == OP_STREAM && stream_ok) begin
                  a_sel  <= 1'b0;
                  a_n    <= ACW'(1);
                  load_q <= 1'b0;
               end else begin
                  a_sel  <= 1'b1;
                  a_n    <= ACW'(ADDR_W);
                  a_word <= cmd_addr;
                  load_q <= 1'b1;
               end
            end
            ST_ALOAD: if (a_fin) begin
               unique case (op_q)
                  OP_PROG: begin
                     d_start <= 1'b1;
                     d_sel   <= 1'b1;
                     d_n     <= DCW'(DATA_W);
                     d_word  <= wdata_q;
                     st      <= ST_WLOAD;
                  end
                  OP_ERASE: begin
                     go_erase <= 1'b1;
                     st       <= ST_HOLD;
                  end
                  default: begin
                     d_start <= 1'b1;
                     d_sel   <= 1'b0;
                     d_n     <= DCW'(1);
                     st      <= ST_CAPT;
                  end
               endcase
            end
            ST_CAPT: if (d_fin) begin
               d_start <= 1'b1;
               d_sel   <= 1'b1;
               d_n     <= DCW'(DATA_W);
               d_word  <= '0;
               st      <= ST_DOUT;
            end
            ST_DOUT: if (d_fin) begin
               rdata     <= d_cap;
               done      <= 1'b1;
               stream_ok <= 1'b1;
               st        <= ST_IDLE;
            end
            ST_WLOAD: if (d_fin) begin
               go_prog <= 1'b1;
               st      <= ST_HOLD;
            end
            ST_HOLD: if (h_fin) begin
               done      <= 1'b1;
               stream_ok <= 1'b0;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_ready_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> done);

   // The address chain samples its own serial output; after a full load it
   // must hold the requested address, proving MSB-first order and count.
   assert_addr_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_fin && load_q) |-> (a_cap == addr_q));

   assert_release_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(arr_prog) || $fell(arr_erase)) |-> !$past(arr_busy));

endmodule

// File: tb/tb_sfa_bridge.sv
module tb_sfa_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int PH         = 2;
   localparam int BUSY_CYC   = 6;

   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] data;
      logic [4:0]  ld, inc, cap, sh;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [8:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        ready, done;
   logic [15:0] rdata;
   logic        arr_aclk, arr_ashift, arr_adin, arr_dclk, arr_dshift, arr_ddin;
   logic        arr_ddout, arr_prog, arr_erase;
   logic        m_busy;

   int n_chk = 0;
   int n_bad = 0;

   sfa_bridge #(.ADDR_W(9), .DATA_W(16), .PHASE_CYC(PH)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .ready(ready), .done(done),
      .rdata(rdata), .arr_aclk(arr_aclk), .arr_ashift(arr_ashift),
      .arr_adin(arr_adin), .arr_dclk(arr_dclk), .arr_dshift(arr_dshift),
      .arr_ddin(arr_ddin), .arr_ddout(arr_ddout), .arr_prog(arr_prog),
      .arr_erase(arr_erase), .arr_busy(m_busy));

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [15:0] init_word(input int i);
      return 16'(i * 16'h0101) ^ 16'h5A3C;
   endfunction

   // ---------------- behavioural array ----------------
   logic [8:0]  m_addr;
   logic [15:0] m_dsh;
   logic [15:0] mem [512];
   logic [3:0]  m_cnt;
   logic        m_armed, m_kind;
   int          m_viol = 0;

   always @(posedge arr_aclk)
      if (arr_ashift) m_addr <= {m_addr[7:0], arr_adin};
      else            m_addr <= m_addr + 9'd1;

   always @(posedge arr_dclk)
      if (arr_dshift) m_dsh <= {m_dsh[14:0], arr_ddin};
      else            m_dsh <= mem[m_addr];

   assign arr_ddout = m_dsh[15];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 512; i++) mem[i] <= init_word(i);
         m_busy <= 1'b0; m_cnt <= '0; m_armed <= 1'b0; m_kind <= 1'b0;
      end else begin
         if (m_busy && !arr_prog && !arr_erase) m_viol <= m_viol + 1;
         if (m_cnt != 0) begin
            m_cnt <= m_cnt - 1'b1;
            if (m_cnt == 1) begin
               m_busy <= 1'b0;
               if (m_kind) mem[m_addr] <= m_dsh;
               else for (int i = 0; i < 512; i++)
                  if (i[8] == m_addr[8]) mem[i] <= 16'hFFFF;
            end
         end else if ((arr_prog || arr_erase) && !m_armed) begin
            m_busy <= 1'b1; m_cnt <= 4'(BUSY_CYC); m_armed <= 1'b1; m_kind <= arr_prog;
         end
         if (!arr_prog && !arr_erase && m_cnt == 0) m_armed <= 1'b0;
      end
   end

   // ---------------- pulse counters ----------------
   int c_ld = 0, c_inc = 0, c_cap = 0, c_sh = 0;
   always @(posedge arr_aclk) if (arr_ashift) c_ld++; else c_inc++;
   always @(posedge arr_dclk) if (arr_dshift) c_sh++; else c_cap++;

   // ---------------- reporting ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- reference model and driver ----------------
   logic [15:0] ref_mem [512];
   logic [8:0]  rp = '0;
   bit          rok = 1'b0;
   exp_t        q[$];

   task automatic issue(input logic [1:0] op, input logic [8:0] addr, input logic [15:0] wd);
      exp_t e;
      @(negedge clk);
      while (!ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
      e = '0; e.op = op;
      case (op)
         2'b00: begin rp = addr; e.ld = 9; e.cap = 1; e.sh = 16; rok = 1'b1; e.data = ref_mem[rp]; end
         2'b01: begin
            if (rok) begin rp = rp + 9'd1; e.inc = 1; end
            else begin rp = addr; e.ld = 9; end
            e.cap = 1; e.sh = 16; rok = 1'b1; e.data = ref_mem[rp];
         end
         2'b10: begin ref_mem[addr] = wd; e.ld = 9; e.sh = 16; rok = 1'b0; end
         default: begin
            for (int i = 0; i < 512; i++) if (i[8] == addr[8]) ref_mem[i] = 16'hFFFF;
            e.ld = 9; rok = 1'b0;
         end
      endcase
      q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // ---------------- monitor ----------------
   int   s_ld = 0, s_inc = 0, s_cap = 0, s_sh = 0;
   bit   prev_done = 1'b0;
   int   hi_w = 0;
   logic prev_aclk = 1'b0, prev_ash = 1'b0, prev_adin = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done && done) chk(1'b0, "R2 done longer than one cycle", 32'd1, 32'd0);
         if (done) begin
            chk(ready, "R2 ready at done", 32'(ready), 32'd1);
            if (q.size() == 0) chk(1'b0, "R2 done without command", 32'd1, 32'd0);
            else begin
               exp_t e;
               e = q.pop_front();
               chk(c_ld - s_ld == int'(e.ld), "R3/R6 address shift pulses", 32'(c_ld - s_ld), 32'(e.ld));
               chk(c_inc - s_inc == int'(e.inc), "R5 increment pulses", 32'(c_inc - s_inc), 32'(e.inc));
               chk(c_cap - s_cap == int'(e.cap), "R4 capture pulses", 32'(c_cap - s_cap), 32'(e.cap));
               chk(c_sh - s_sh == int'(e.sh), "R4/R7 data shift pulses", 32'(c_sh - s_sh), 32'(e.sh));
               if (e.op[1] == 1'b0)
                  chk(rdata == e.data, "R4/R5 read data", 32'(rdata), 32'(e.data));
            end
            s_ld = c_ld; s_inc = c_inc; s_cap = c_cap; s_sh = c_sh;
         end
         // R9: high phase width and line stability while clock is high
         if (arr_aclk) begin
            hi_w++;
            if (prev_aclk)
               chk(arr_ashift == prev_ash && arr_adin == prev_adin,
                   "R9 address lines moved while clock high",
                   32'({arr_ashift, arr_adin}), 32'({prev_ash, prev_adin}));
         end else if (prev_aclk) begin
            chk(hi_w == PH, "R9 clock high width", 32'(hi_w), 32'(PH));
            hi_w = 0;
         end
         if (arr_prog && arr_erase) chk(1'b0, "R8 both requests high", 32'd1, 32'd0);
         prev_done = done; prev_aclk = arr_aclk; prev_ash = arr_ashift; prev_adin = arr_adin;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 512; i++) ref_mem[i] = init_word(i);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ready == 1'b1, "R1 ready in reset", 32'(ready), 32'd1);
      chk({done, arr_aclk, arr_dclk, arr_ashift, arr_dshift, arr_prog, arr_erase} == '0,
          "R1 outputs low in reset",
          32'({done, arr_aclk, arr_dclk, arr_ashift, arr_dshift, arr_prog, arr_erase}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1 && done == 1'b0, "R1 ready after reset", 32'({ready, done}), 32'b10);

      issue(2'b01, 9'h033, '0);   // R6: stream-next at start loads the address
      issue(2'b00, 9'h000, '0);   // R4: reads of varied patterns
      issue(2'b00, 9'h1FF, '0);
      issue(2'b00, 9'h155, '0);
      issue(2'b00, 9'h1FD, '0);
      issue(2'b01, 9'h000, '0);   // R5: 1FE
      issue(2'b01, 9'h000, '0);   // R5: 1FF
      issue(2'b01, 9'h000, '0);   // R5: wraps to 000
      issue(2'b10, 9'h0AA, 16'h1234); // R7: program
      issue(2'b01, 9'h0AB, '0);   // R6: stream after program reloads
      issue(2'b00, 9'h0AA, '0);   // R7: read back programmed word
      issue(2'b11, 9'h100, '0);   // R8: erase upper half
      issue(2'b00, 9'h1FF, '0);   // R8: erased word
      issue(2'b00, 9'h0FF, '0);   // R8: other half unchanged
      issue(2'b01, 9'h000, '0);   // R6: stream after erase reloads

      // R10: command offered while busy is ignored
      issue(2'b00, 9'h020, '0);
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 9'h020; cmd_wdata = 16'hDEAD;
      chk(ready == 1'b0, "R10 ready low during operation", 32'(ready), 32'd0);
      repeat (4) @(negedge clk);
      cmd_valid = 1'b0;
      issue(2'b00, 9'h020, '0);   // R10: word untouched

      while (q.size() != 0 || !ready) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(m_viol == 0, "R7 request dropped while busy", 32'(m_viol), 32'd0);
      chk(q.size() == 0, "R2 every command completed", 32'(q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule